// File: doc/BRIEF.md
# Serial Port with Hardware Handshake

This block is a small 8N1 asynchronous serial port. It has an eight-entry receive queue and an eight-entry transmit queue. Software configures it through a two-register write/read port and moves bytes through a push port on the transmit side and a pop port on the receive side. The serial side has a transmit line, a receive line, a request-to-send output and a clear-to-send input.

The control register turns the receiver and the transmitter on and off. It also arms two handshakes. With automatic request-to-send armed, the block drives the request line from the number of free receive entries, and a 2-bit code selects the free-space threshold. With automatic clear-to-send armed, a character starts only while the synchronized clear line reads as active. Each handshake line has its own polarity-invert bit. When automatic request-to-send is off, the request line copies a software-written bit.

The bit clock is derived from a tick divider. Every serial bit lasts exactly eight ticks, and each tick is `TICK_DIV` clock cycles long.

Top module: `flowuart`

## Requirements
- R1: After reset the control register reads 0x03 (receiver and transmitter enabled, every other bit clear). The modem register reads 0. The request line is low, the transmit line is high and both queues are empty.
- R2: The control register (`reg_addr`=0) reads back what was written. Its bit positions are: bit0 receiver enable, bit1 transmitter enable, bit2 automatic request, bit3 automatic clear, bits5:4 threshold code, bit6 request invert, bit7 clear invert. The modem register (`reg_addr`=1) keeps its bit0 as the software request bit.
- R3: With automatic request on and no inversion, `rts_pin` is 1 while the receive free space is greater than the threshold and 0 otherwise. The threshold codes are 00→3, 01→2, 10→1 and 11→4 free entries.
- R4: With automatic clear on, a new character starts only while `cts_pin` reads active (1 when not inverted). `cts_pin` passes through two synchronizer flops first. A character already started finishes even if the clear line drops partway through it.
- R5: With automatic request off, `rts_pin` follows modem bit0 one cycle after the register changes, and the request-invert bit has no effect.
- R6: The request-invert bit complements the automatic request output. The clear-invert bit makes a low `cts_pin` count as clear.
- R7: Each queue holds 8 bytes. A push to a full transmit queue is dropped. A received frame that arrives while the receive queue is full is dropped.
- R8: While the receiver is disabled, incoming frames are ignored and the receive queue is unchanged.
- R9: Frames are one low start bit, 8 data bits LSB first, and one high stop bit, each bit lasting 8*`TICK_DIV` cycles. A frame with a low stop bit is discarded. The transmit line idles high.
- R10: While the transmitter is disabled, pushed bytes stay queued and the transmit line stays high. Enabling the transmitter sends them in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects modem |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| tx_level | output | CW | Transmit queue occupancy |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| rx_level | output | CW | Receive queue occupancy |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rts_pin | output | 1 | Request-to-send output |
| cts_pin | input | 1 | Clear-to-send input |

## Verification
The bench walks the receive occupancy across all four threshold codes. A design with the codes in numeric order, or with an off-by-one comparison, shows a wrong request level at one of these points. It drops the clear line in the middle of a character: a design that aborts the character corrupts the byte, and one that ignores the line starts the queued byte anyway. It overfills both queues and sends frames to a disabled receiver. A design that wraps its pointers on overflow, or that keeps frames while disabled, returns the wrong bytes or the wrong occupancy.

// File: rtl/flowuart_pkg.sv
package flowuart_pkg;

    typedef struct packed {
        logic       cts_inv;
        logic       rts_inv;
        logic [1:0] rts_thr;
        logic       auto_cts;
        logic       auto_rts;
        logic       tx_en;
        logic       rx_en;
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h03;

    // free-entry threshold selected by the 2-bit code (not in numeric order)
    function automatic logic [2:0] thr_free(input logic [1:0] code);
        case (code)
            2'b00:   thr_free = 3'd3;
            2'b01:   thr_free = 3'd2;
            2'b10:   thr_free = 3'd1;
            default: thr_free = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/flowuart_fifo.sv
module flowuart_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CW'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.wp] = din;
            d.wp = (q.wp == PW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop)
            d.rp = (q.rp == PW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        if (do_push && !do_pop)
            d.cnt = q.cnt + 1'b1;
        else if (do_pop && !do_push)
            d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout  = q.mem[q.rp];
    assign count = q.cnt;
endmodule

// File: rtl/flowuart_tx.sv
module flowuart_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] din,
    output logic       txd,
    output logic       busy
);
    typedef struct packed {
        logic       busy;
        logic [9:0] sh;
        logic [2:0] cnt;
        logic [3:0] nbit;
    } tx_st_t;

    tx_st_t q, d;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.sh   = {1'b1, din, 1'b0};
                d.cnt  = '0;
                d.nbit = '0;
            end
        end else if (tick) begin
            if (q.cnt == 3'd7) begin
                d.cnt = '0;
                d.sh  = {1'b1, q.sh[9:1]};
                if (q.nbit == 4'd9) d.busy = 1'b0;
                else                d.nbit = q.nbit + 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, sh: '1, cnt: '0, nbit: '0};
        else        q <= d;
    end

    assign txd  = q.busy ? q.sh[0] : 1'b1;
    assign busy = q.busy;
endmodule

// File: rtl/flowuart_rx.sv
module flowuart_rx #(
    parameter int HALF_TICKS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       rxd,
    output logic       valid,
    output logic [7:0] data
);
    typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;

    typedef struct packed {
        logic       s1;
        logic       s2;
        rx_state_e  st;
        logic [2:0] cnt;
        logic [2:0] nbit;
        logic [7:0] sh;
        logic       valid;
    } rx_st_t;

    rx_st_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.s1    = rxd;
        d.s2    = q.s1;
        case (q.st)
            S_IDLE:
                if (tick && en && !q.s2) begin
                    d.st  = S_START;
                    d.cnt = '0;
                end
            S_START:
                if (tick) begin
                    if (q.cnt == 3'(HALF_TICKS - 1)) begin
                        d.st   = q.s2 ? S_IDLE : S_DATA;
                        d.cnt  = '0;
                        d.nbit = '0;
                    end else d.cnt = q.cnt + 1'b1;
                end
            S_DATA:
                if (tick) begin
                    if (q.cnt == 3'd7) begin
                        d.cnt  = '0;
                        d.sh   = {q.s2, q.sh[7:1]};
                        d.nbit = q.nbit + 1'b1;
                        if (q.nbit == 3'd7) d.st = S_STOP;
                    end else d.cnt = q.cnt + 1'b1;
                end
            default:
                if (tick) begin
                    if (q.cnt == 3'd7) begin
                        d.valid = q.s2 && en;
                        d.st    = S_IDLE;
                        d.cnt   = '0;
                    end else d.cnt = q.cnt + 1'b1;
                end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: 1'b1, s2: 1'b1, st: S_IDLE, cnt: '0, nbit: '0, sh: '0, valid: 1'b0};
        else        q <= d;
    end

    assign valid = q.valid;
    assign data  = q.sh;
endmodule

// File: rtl/flowuart.sv
module flowuart
    import flowuart_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int TICK_DIV = 2,
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int TW      = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic          reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          tx_push,
    input  logic [7:0]    tx_data,
    output logic [CW-1:0] tx_level,
    input  logic          rx_pop,
    output logic [7:0]    rx_data,
    output logic [CW-1:0] rx_level,
    output logic          txd,
    input  logic          rxd,
    output logic          rts_pin,
    input  logic          cts_pin
);
    typedef struct packed {
        ctrl_t         ctrl;
        logic          mcr;
        logic          cts_s1;
        logic          cts_s2;
        logic          rts;
        logic [TW-1:0] tdiv;
    } top_st_t;

    top_st_t q, d;

    logic          tick, cts_ok, tx_start, tx_busy;
    logic          rx_valid;
    logic [7:0]    rx_byte, tx_head;
    logic [CW-1:0] rx_free;
    logic [7:0]    ctrl_w;

    always_comb begin
        d      = q;
        tick   = (q.tdiv == TW'(TICK_DIV - 1));
        d.tdiv = tick ? '0 : q.tdiv + 1'b1;
        d.cts_s1 = cts_pin;
        d.cts_s2 = q.cts_s1;
        if (reg_we) begin
            if (reg_addr) d.mcr  = reg_wdata[0];
            else          d.ctrl = ctrl_t'(reg_wdata);
        end
        rx_free = CW'(DEPTH) - rx_level;
        if (q.ctrl.auto_rts)
            d.rts = (rx_free > CW'(thr_free(q.ctrl.rts_thr))) ^ q.ctrl.rts_inv;
        else
            d.rts = q.mcr;
        cts_ok   = q.cts_s2 ^ q.ctrl.cts_inv;
        tx_start = q.ctrl.tx_en && !tx_busy && (tx_level != '0)
                   && (!q.ctrl.auto_cts || cts_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ctrl: ctrl_t'(CTRL_RESET), mcr: 1'b0, cts_s1: 1'b0,
                           cts_s2: 1'b0, rts: 1'b0, tdiv: '0};
        else        q <= d;
    end

    flowuart_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_data),
        .pop(tx_start), .dout(tx_head), .count(tx_level));

    flowuart_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_valid), .din(rx_byte),
        .pop(rx_pop), .dout(rx_data), .count(rx_level));

    flowuart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start),
        .din(tx_head), .txd(txd), .busy(tx_busy));

    flowuart_rx #(.HALF_TICKS(3)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(q.ctrl.rx_en),
        .rxd(rxd), .valid(rx_valid), .data(rx_byte));

    assign ctrl_w    = q.ctrl;
    assign reg_rdata = reg_addr ? {7'b0, q.mcr} : ctrl_w;
    assign rts_pin   = q.rts;
endmodule

// File: rtl/flowuart_chk.sv
module flowuart_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    ctrl,
    input logic          mcr,
    input logic          cts_ok,
    input logic          tx_busy,
    input logic          txd,
    input logic          rts_pin,
    input logic          rx_pop,
    input logic [CW-1:0] rx_level
);
    p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= CW'(DEPTH));

    p_rts_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[2] && ($past(ctrl) == ctrl) && ($past(rx_level) == CW'(DEPTH)))
        |-> (rts_pin == ctrl[6]));

    p_rts_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[2] && ($past(ctrl) == ctrl) && ($past(rx_level) == '0))
        |-> (rts_pin == !ctrl[6]));

    p_rts_manual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl[2]) |-> (rts_pin == $past(mcr)));

    p_cts_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> ($past(ctrl[1]) && (!$past(ctrl[3]) || $past(cts_ok))));

    p_rx_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[0] && !rx_pop) |=> (rx_level <= $past(rx_level)));

    p_txd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);
endmodule

bind flowuart flowuart_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_w), .mcr(q.mcr), .cts_ok(cts_ok),
    .tx_busy(tx_busy), .txd(txd), .rts_pin(rts_pin), .rx_pop(rx_pop),
    .rx_level(rx_level));

// File: tb/flowuart_test.sv
module flowuart_test;
    localparam int CLK_P    = 10;
    localparam int TICK_DIV = 2;
    localparam int BITC     = 8 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       tx_push = 1'b0;
    logic [7:0] tx_data = '0;
    logic [3:0] tx_level, rx_level;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_data;
    logic       txd, rts_pin;
    logic       rxd = 1'b1, cts_pin = 1'b1;

    int compared = 0;
    int mismatched = 0;

    flowuart #(.DEPTH(8), .TICK_DIV(TICK_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_push(tx_push),
        .tx_data(tx_data), .tx_level(tx_level), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_level(rx_level), .txd(txd), .rxd(rxd),
        .rts_pin(rts_pin), .cts_pin(cts_pin));

    always #(CLK_P / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 1'b0;
        wait_n(3);
    endtask

    task automatic rreg(input logic a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
        reg_addr = 1'b0;
    endtask

    task automatic rx_frame(input logic [7:0] b);
        logic [9:0] f;
        f = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rxd = f[i];
            repeat (BITC - 1) @(negedge clk);
        end
        wait_n(BITC);
    endtask

    task automatic pop_rx(output logic [7:0] b);
        @(negedge clk);
        b = rx_data;
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk);
        tx_push = 1'b1; tx_data = b;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    // returns 1 if txd went low at any sampled point
    task automatic txd_went_low(input int n, output logic low);
        low = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!txd) low = 1'b1;
        end
    endtask

    task automatic cap_tx(input logic drop_cts, output logic [7:0] b, output logic stop);
        int t;
        t = 0;
        b = '0; stop = 1'b0;
        while (txd && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (drop_cts) cts_pin = 1'b0;
        wait_n(BITC / 2);
        for (int i = 0; i < 8; i++) begin
            wait_n(BITC);
            b[i] = txd;
        end
        wait_n(BITC);
        stop = txd;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rreg(1'b0, v); check("R1 ctrl reset", v, 8'h03);
        rreg(1'b1, v); check("R1 modem reset", v, 0);
        check("R1 rts reset", rts_pin, 0);
        check("R1 txd idle", txd, 1);
        check("R1 rx empty", rx_level, 0);
        check("R1 tx empty", tx_level, 0);
    endtask

    task automatic t_ctrl_rw;
        logic [7:0] v;
        wreg(1'b0, 8'hF4);
        rreg(1'b0, v); check("R2 ctrl readback", v, 8'hF4);
        wreg(1'b0, 8'h03);
        wreg(1'b1, 8'h01);
        rreg(1'b1, v); check("R2 modem readback", v, 1);
        wreg(1'b1, 8'h00);
    endtask

    task automatic t_manual_rts;
        wreg(1'b1, 8'h01); check("R5 manual rts high", rts_pin, 1);
        wreg(1'b1, 8'h00); check("R5 manual rts low", rts_pin, 0);
        wreg(1'b0, 8'h43);
        wreg(1'b1, 8'h01); check("R5 invert ignored when manual", rts_pin, 1);
        wreg(1'b1, 8'h00);
        wreg(1'b0, 8'h03);
    endtask

    task automatic t_tx_basic;
        logic [7:0] b; logic s;
        push_tx(8'hA5); push_tx(8'h3C);
        cap_tx(1'b0, b, s); check("R9 tx byte 0", b, 8'hA5); check("R9 tx stop", s, 1);
        cap_tx(1'b0, b, s); check("R9 tx byte 1", b, 8'h3C);
        wait_n(3 * BITC);
    endtask

    task automatic t_rx_basic;
        logic [7:0] b;
        rx_frame(8'h5A); rx_frame(8'hC3);
        check("R9 rx level", rx_level, 2);
        pop_rx(b); check("R9 rx byte 0", b, 8'h5A);
        pop_rx(b); check("R9 rx byte 1", b, 8'hC3);
    endtask

    task automatic t_rts_thr;
        logic [7:0] b;
        wreg(1'b0, 8'h07);
        check("R3 rts empty", rts_pin, 1);
        for (int k = 1; k <= 5; k++) begin
            rx_frame(8'(8'h10 + k));
            check("R3 rts code00 vs fill", rts_pin, (8 - k > 3) ? 1 : 0);
        end
        wreg(1'b0, 8'h17); check("R3 code01 free3", rts_pin, 1);
        wreg(1'b0, 8'h27); check("R3 code10 free3", rts_pin, 1);
        wreg(1'b0, 8'h37); check("R3 code11 free3", rts_pin, 0);
        wreg(1'b0, 8'h47); check("R6 rts inverted", rts_pin, 1);
        for (int k = 1; k <= 5; k++) pop_rx(b);
        wait_n(2);
        check("R6 rts inverted empty", rts_pin, 0);
        wreg(1'b0, 8'h03);
    endtask

    task automatic t_fifo_full;
        logic [7:0] b; logic s, low;
        for (int i = 0; i < 9; i++) rx_frame(8'(8'h20 + i));
        check("R7 rx full level", rx_level, 8);
        for (int i = 0; i < 8; i++) begin
            pop_rx(b); check("R7 rx order", b, 8'h20 + i);
        end
        check("R7 rx drained", rx_level, 0);
        wreg(1'b0, 8'h01);
        for (int i = 0; i < 9; i++) push_tx(8'(8'h30 + i));
        txd_went_low(300, low);
        check("R10 txd held while disabled", low, 0);
        check("R7 tx full level", tx_level, 8);
        wreg(1'b0, 8'h03);
        for (int i = 0; i < 8; i++) begin
            cap_tx(1'b0, b, s); check("R10 tx order after enable", b, 8'h30 + i);
        end
        wait_n(3 * BITC);
        check("R7 tx drained", tx_level, 0);
    endtask

    task automatic t_rx_off;
        logic [7:0] b;
        wreg(1'b0, 8'h02);
        rx_frame(8'h77);
        check("R8 rx disabled level", rx_level, 0);
        wreg(1'b0, 8'h03);
        rx_frame(8'h99);
        check("R8 rx re-enabled level", rx_level, 1);
        pop_rx(b); check("R8 no stale byte", b, 8'h99);
    endtask

    task automatic t_cts;
        logic [7:0] b; logic s, low;
        cts_pin = 1'b0;
        wreg(1'b0, 8'h0B);
        push_tx(8'h61);
        txd_went_low(400, low);
        check("R4 held by cts", low, 0);
        check("R4 byte still queued", tx_level, 1);
        cts_pin = 1'b1;
        cap_tx(1'b0, b, s); check("R4 sent after cts", b, 8'h61);
        wait_n(3 * BITC);
        push_tx(8'h62); push_tx(8'h63);
        cap_tx(1'b1, b, s);
        check("R4 in-flight completes", b, 8'h62); check("R4 in-flight stop", s, 1);
        txd_went_low(400, low);
        check("R4 next held", low, 0);
        check("R4 next queued", tx_level, 1);
        wreg(1'b0, 8'h8B);
        cap_tx(1'b0, b, s); check("R6 inverted cts sends", b, 8'h63);
        wait_n(3 * BITC);
        cts_pin = 1'b1;
        wreg(1'b0, 8'h03);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        t_reset();
        t_ctrl_rw();
        t_manual_rts();
        t_tx_basic();
        t_rx_basic();
        t_rts_thr();
        t_fifo_full();
        t_rx_off();
        t_cts();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end
endmodule